// File: doc/BRIEF.md
# Colour Adjustment Stage with Field-Synchronous Parameter Update

This block takes a demultiplexed stream of luma and colour-difference samples (one Y, one Cb and one Cr per valid cycle) and applies picture controls to it. Luma is first multiplied by a contrast factor and then shifted by a signed brightness offset. Each colour-difference component is multiplied by its own saturation factor around the 128 midpoint. The result passes through a fixed two-stage pipeline, and every output saturates to the code range 1 to 254.

Control values are written one byte at a time through a small write port into a shadow set. When double buffering is enabled, the shadow set is copied into the working set only when the vertical sync input falls. Picture changes therefore always start at a field boundary and never in the middle of a field. When double buffering is disabled, each write reaches the working set at the next clock edge.

Top module: `colour_adjust_top`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0, and the working set holds contrast 128, brightness 0, Cb saturation 128 and Cr saturation 128. With these values each component passes through unchanged.
- R2: out_y = clamp(((Y*C + 64) >> 7) + B, 1, 254). C is the working contrast (an unsigned factor in units of 1/128) and B is the working brightness.
- R3: A contrast write of a value above 192 is stored as 192, which caps contrast at 150 %.
- R4: Each chroma output is clamp(((((X-128)*S) + 64) >>> 7) + 128, 1, 254). X is that component's input, S is that component's own unsigned saturation factor (units of 1/128), and >>> is an arithmetic shift that rounds toward minus infinity.
- R5: out_valid is in_valid delayed by exactly two clock cycles. The data of each sample appears in the same cycle as its valid strobe.
- R6: With dbuf_en high, a write does not change any output until vsync is sampled low in a cycle after it was sampled high. Samples presented in the cycle after that edge use the new values.
- R7: With dbuf_en low, a write affects the sample presented in the cycle after the write.
- R8: When a write and a vsync falling edge occur in the same cycle, the written value is part of the set copied at that edge.
- R9: A rising edge of vsync, or vsync held at a steady level, does not copy the shadow set when dbuf_en is high.
- R10: Write address map (wr_addr): 0 is contrast, 1 is brightness (two's complement, -128 to 127), 2 is Cb saturation, 3 is Cr saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control write strobe |
| wr_addr | input | 2 | Control register select |
| wr_data | input | 8 | Control write value |
| dbuf_en | input | 1 | 1: defer updates to vsync fall; 0: apply immediately |
| vsync | input | 1 | Vertical sync level |
| in_valid | input | 1 | Input sample valid |
| in_y | input | 8 | Luma input |
| in_cb | input | 8 | Cb input |
| in_cr | input | 8 | Cr input |
| out_valid | output | 1 | Output sample valid |
| out_y | output | 8 | Adjusted luma |
| out_cb | output | 8 | Adjusted Cb |
| out_cr | output | 8 | Adjusted Cr |

## Verification
Two events can land in the same cycle: a control write, and the vsync falling edge that copies the shadow set. The bench provokes this on purpose by presenting a saturation write in the same cycle that vsync first reads low. It then judges the samples that follow: they must already reflect the new factor. A cycle-accurate reference model in the bench tracks the shadow and working sets. This model also checks that the sample presented alongside a write or an edge still uses the old values, and that rising or steady vsync never copies.

// File: rtl/colour_adj_pkg.sv
// Package: shared widths, control-set type, address map and clamp helper
// for the colour adjustment stage. Assumes 8-bit samples and 8-bit factors.
package colour_adj_pkg;
    localparam int DATA_W    = 8;
    localparam int COEF_W    = 8;
    localparam int FRAC_BITS = 7;
    localparam int ADDR_W    = 2;
    localparam int CONTRAST_CAP = 192;
    localparam int UNITY        = 1 << FRAC_BITS;
    localparam int MIDPOINT     = 128;
    localparam int CODE_MIN     = 1;
    localparam int CODE_MAX     = 254;

    localparam logic [ADDR_W-1:0] A_CONTRAST = 2'd0;
    localparam logic [ADDR_W-1:0] A_BRIGHT   = 2'd1;
    localparam logic [ADDR_W-1:0] A_SAT_CB   = 2'd2;
    localparam logic [ADDR_W-1:0] A_SAT_CR   = 2'd3;

    typedef struct packed {
        logic [COEF_W-1:0] contrast;
        logic [COEF_W-1:0] bright;
        logic [COEF_W-1:0] sat_cb;
        logic [COEF_W-1:0] sat_cr;
    } adj_set_t;

    localparam adj_set_t ADJ_DEFAULT = '{
        contrast: COEF_W'(UNITY),
        bright:   '0,
        sat_cb:   COEF_W'(UNITY),
        sat_cr:   COEF_W'(UNITY)
    };

    // Saturate a signed intermediate value to the legal output code range.
    function automatic logic [DATA_W-1:0] clamp_code(input logic signed [15:0] v);
        if (v < 16'sd1)
            return DATA_W'(CODE_MIN);
        else if (v > 16'sd254)
            return DATA_W'(CODE_MAX);
        else
            return v[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/adj_regs.sv
// Control register bank: a shadow set loaded from the write port and a
// working set copied from it on a vsync falling edge (double buffering on)
// or every cycle (off). A write in the copy cycle is included in the copy.
module adj_regs
    import colour_adj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [COEF_W-1:0] wr_data,
    input  logic              dbuf_en,
    input  logic              vsync,
    output adj_set_t          act
);
    adj_set_t shadow_q;
    adj_set_t shadow_nx;
    logic     vsync_q;
    logic     vs_fall;
    logic [COEF_W-1:0] contrast_wr;

    // Contrast value after the 150 % cap.
    assign contrast_wr = (wr_data > COEF_W'(CONTRAST_CAP)) ? COEF_W'(CONTRAST_CAP) : wr_data;

    // Falling edge of vsync, seen against its value in the previous cycle.
    assign vs_fall = vsync_q && !vsync;

    // Shadow set with this cycle's write merged in.
    always_comb begin
        shadow_nx = shadow_q;
        if (wr_en) begin
            case (wr_addr)
                A_CONTRAST: shadow_nx.contrast = contrast_wr;
                A_BRIGHT:   shadow_nx.bright   = wr_data;
                A_SAT_CB:   shadow_nx.sat_cb   = wr_data;
                default:    shadow_nx.sat_cr   = wr_data;
            endcase
        end
    end

    // Shadow, working set and vsync history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= ADJ_DEFAULT;
            act      <= ADJ_DEFAULT;
            vsync_q  <= 1'b0;
        end else begin
            shadow_q <= shadow_nx;
            vsync_q  <= vsync;
            if (!dbuf_en || vs_fall)
                act <= shadow_nx;
        end
    end

    AST_CONTRAST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        act.contrast <= COEF_W'(CONTRAST_CAP)); // R3
    AST_HOLD_UNTIL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_en && !(vsync_q && !vsync)) |=> $stable(act)); // R6
    AST_IMMEDIATE_BRIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbuf_en && wr_en && wr_addr == A_BRIGHT) |=> act.bright == $past(wr_data)); // R7
    AST_FALL_INCLUDES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_en && vsync_q && !vsync && wr_en && wr_addr == A_SAT_CB) |=> act.sat_cb == $past(wr_data)); // R8
endmodule

// File: rtl/luma_adj.sv
// Luma path: stage 1 scales by contrast with rounding and captures the
// brightness used for the same sample; stage 2 adds brightness and clamps.
module luma_adj
    import colour_adj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] y_in,
    input  logic [COEF_W-1:0] contrast,
    input  logic [COEF_W-1:0] bright,
    output logic [DATA_W-1:0] y_out
);
    localparam int PW = DATA_W + COEF_W;
    localparam int SW = PW - FRAC_BITS;
    localparam int TW = SW + 2;

    logic [PW-1:0]     prod;
    logic [PW-1:0]     rounded;
    logic [SW-1:0]     scaled_q;
    logic [COEF_W-1:0] bright_q;
    logic signed [TW-1:0] sum;

    // Contrast product with half-LSB rounding.
    assign prod    = PW'(y_in) * PW'(contrast);
    assign rounded = (prod + PW'(UNITY / 2)) >> FRAC_BITS;

    // Stage 1 register: scaled luma and its brightness.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scaled_q <= '0;
            bright_q <= '0;
        end else begin
            scaled_q <= rounded[SW-1:0];
            bright_q <= bright;
        end
    end

    // Brightness offset added as a signed value.
    assign sum = $signed({2'b00, scaled_q}) + TW'($signed(bright_q));

    // Stage 2 register: clamped luma.
    always_ff @(posedge clk) begin
        if (!rst_n)
            y_out <= '0;
        else
            y_out <= clamp_code(16'(sum));
    end
endmodule

// File: rtl/chroma_adj.sv
// One colour-difference path: stage 1 scales (X-128) by the saturation
// factor with rounding toward minus infinity; stage 2 re-centres and clamps.
module chroma_adj
    import colour_adj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] x_in,
    input  logic [COEF_W-1:0] sat,
    output logic [DATA_W-1:0] x_out
);
    localparam int DW1 = DATA_W + 1;
    localparam int PW  = DW1 + COEF_W + 1;
    localparam int RW  = PW - FRAC_BITS;
    localparam logic signed [DW1-1:0] MID_S = DW1'(MIDPOINT);

    logic signed [DW1-1:0] diff;
    logic signed [PW-1:0]  prod;
    logic signed [PW-1:0]  rnd_full;
    logic signed [RW-1:0]  rnd_q;
    logic signed [RW:0]    sum;

    // Signed offset from the midpoint, scaled and rounded.
    assign diff     = $signed({1'b0, x_in}) - MID_S;
    assign prod     = PW'(diff) * $signed({{(PW-COEF_W){1'b0}}, sat});
    assign rnd_full = (prod + PW'(UNITY / 2)) >>> FRAC_BITS;

    // Stage 1 register: scaled difference.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rnd_q <= '0;
        else
            rnd_q <= $signed(rnd_full[RW-1:0]);
    end

    assign sum = (RW+1)'(rnd_q) + (RW+1)'(MIDPOINT);

    // Stage 2 register: re-centred, clamped component.
    always_ff @(posedge clk) begin
        if (!rst_n)
            x_out <= '0;
        else
            x_out <= clamp_code(16'(sum));
    end
endmodule

// File: rtl/colour_adjust_top.sv
// Top: control bank, luma path, two chroma paths built by generate, and the
// matching two-cycle valid pipeline. Assumes samples arrive demultiplexed.
module colour_adjust_top
    import colour_adj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              dbuf_en,
    input  logic              vsync,
    input  logic              in_valid,
    input  logic [7:0]        in_y,
    input  logic [7:0]        in_cb,
    input  logic [7:0]        in_cr,
    output logic              out_valid,
    output logic [7:0]        out_y,
    output logic [7:0]        out_cb,
    output logic [7:0]        out_cr
);
    localparam int NCHROMA = 2;
    localparam int LAT     = 2;

    adj_set_t act;
    logic [LAT-1:0]     vld_pipe;
    logic [1:0]         warm_q;
    logic [DATA_W-1:0]  c_in  [NCHROMA];
    logic [DATA_W-1:0]  c_out [NCHROMA];
    logic [COEF_W-1:0]  c_sat [NCHROMA];

    adj_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dbuf_en(dbuf_en), .vsync(vsync), .act(act)
    );

    luma_adj u_luma (
        .clk(clk), .rst_n(rst_n), .y_in(in_y), .contrast(act.contrast),
        .bright(act.bright), .y_out(out_y)
    );

    assign c_in[0]  = in_cb;
    assign c_in[1]  = in_cr;
    assign c_sat[0] = act.sat_cb;
    assign c_sat[1] = act.sat_cr;

    for (genvar g = 0; g < NCHROMA; g++) begin : g_chroma
        chroma_adj u_chroma (
            .clk(clk), .rst_n(rst_n), .x_in(c_in[g]), .sat(c_sat[g]),
            .x_out(c_out[g])
        );
    end

    assign out_cb = c_out[0];
    assign out_cr = c_out[1];

    // Valid strobe delayed to match the datapath.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_pipe <= '0;
        else
            vld_pipe <= {vld_pipe[LAT-2:0], in_valid};
    end
    assign out_valid = vld_pipe[LAT-1];

    // Cycles since reset, saturating, for history-based checks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm_q <= '0;
        else if (warm_q != 2'd2)
            warm_q <= warm_q + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> out_valid == $past(in_valid, 2)); // R5
    AST_LUMA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_y >= 8'd1 && out_y <= 8'd254)); // R2
    AST_CHROMA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cb >= 8'd1 && out_cb <= 8'd254 && out_cr >= 8'd1 && out_cr <= 8'd254)); // R4
endmodule

// File: tb/test_colour_adjust_top.sv
module test_colour_adjust_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic dbuf_en = 1'b0;
    logic vsync = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_y = '0, in_cb = '0, in_cr = '0;
    logic out_valid;
    logic [7:0] out_y, out_cb, out_cr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state: shadow and working sets, vsync history.
    int sh [4];
    int ac [4];
    bit prev_vs = 0;
    // Two-deep expected pipeline.
    bit    e_v [2];
    int    e_y [2], e_cb [2], e_cr [2];
    string e_t [2];

    always #5 clk = ~clk;

    colour_adjust_top i_colour_adjust_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dbuf_en(dbuf_en), .vsync(vsync),
        .in_valid(in_valid), .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
        .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
    );

    function automatic int clampc(int v);
        return (v < 1) ? 1 : (v > 254) ? 254 : v;
    endfunction
    function automatic int luma_exp(int y, int c, int b);
        return clampc(((y * c + 64) >>> 7) + b);
    endfunction
    function automatic int chroma_exp(int x, int s);
        return clampc((((x - 128) * s + 64) >>> 7) + 128);
    endfunction

    task automatic check_out();
        checks++;
        if (out_valid !== e_v[1]) begin
            errors++;
            $display("FAIL %s out_valid actual %0b expected %0b", e_t[1], out_valid, e_v[1]);
        end else if (e_v[1] && (out_y != e_y[1] || out_cb != e_cb[1] || out_cr != e_cr[1])) begin
            errors++;
            $display("FAIL %s Y/Cb/Cr actual %0d/%0d/%0d expected %0d/%0d/%0d", e_t[1],
                     out_y, out_cb, out_cr, e_y[1], e_cb[1], e_cr[1]);
        end
    endtask

    // One cycle: check outputs, drive inputs, update model, advance.
    task automatic step(bit v, int y, int cb, int cr, bit we, int wa, int wd,
                        bit db, bit vs, string tag);
        check_out();
        in_valid = v; in_y = 8'(y); in_cb = 8'(cb); in_cr = 8'(cr);
        wr_en = we; wr_addr = 2'(wa); wr_data = 8'(wd);
        dbuf_en = db; vsync = vs;
        e_v[1] = e_v[0]; e_y[1] = e_y[0]; e_cb[1] = e_cb[0]; e_cr[1] = e_cr[0]; e_t[1] = e_t[0];
        e_v[0] = v;
        e_y[0] = luma_exp(y, ac[0], ac[1]);
        e_cb[0] = chroma_exp(cb, ac[2]);
        e_cr[0] = chroma_exp(cr, ac[3]);
        e_t[0] = tag;
        if (we) begin
            if (wa == 0) sh[0] = (wd > 192) ? 192 : wd;
            else if (wa == 1) sh[1] = int'($signed(8'(wd)));
            else sh[wa] = wd;
        end
        if (!db || (prev_vs && !vs)) ac = sh;
        prev_vs = vs;
        @(negedge clk);
    endtask

    task automatic rnd_sample(bit db, bit vs, string tag);
        step(1, $urandom_range(254, 1), $urandom_range(254, 1), $urandom_range(254, 1),
             0, 0, 0, db, vs, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        sh = '{128, 0, 128, 128};
        ac = sh;
        e_v = '{0, 0};
        e_t = '{"R5", "R5"};
        e_y = '{0, 0}; e_cb = '{0, 0}; e_cr = '{0, 0};
        repeat (4) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 out_valid in reset actual %0b expected 0", out_valid);
        end
        rst_n = 1'b1;
        // R1: defaults pass samples through unchanged.
        step(1, 100, 60, 200, 0, 0, 0, 0, 0, "R1");
        step(1, 16, 128, 240, 0, 0, 0, 0, 0, "R1");
        // R5: gaps in valid.
        step(0, 50, 50, 50, 0, 0, 0, 0, 0, "R5");
        step(1, 235, 16, 128, 0, 0, 0, 0, 0, "R5");
        // R7/R10: immediate writes, sample alongside still old.
        step(1, 120, 90, 170, 1, 0, 160, 0, 0, "R7");
        step(1, 120, 90, 170, 1, 1, 8'hF0, 0, 0, "R10");
        step(1, 120, 90, 170, 1, 2, 200, 0, 0, "R10");
        step(1, 120, 90, 170, 1, 3, 40, 0, 0, "R4");
        step(1, 120, 90, 170, 0, 0, 0, 0, 0, "R7");
        // R3: contrast above cap.
        step(1, 100, 128, 128, 1, 0, 255, 0, 0, "R3");
        step(1, 100, 128, 128, 1, 1, 0, 0, 0, "R3");
        step(1, 100, 128, 128, 0, 0, 0, 0, 0, "R3");
        // R2/R4: clamp corners.
        step(1, 254, 254, 1, 1, 1, 127, 0, 0, "R2");
        step(1, 254, 254, 1, 1, 2, 255, 0, 0, "R2");
        step(1, 254, 254, 1, 1, 3, 255, 0, 0, "R4");
        step(1, 1, 1, 254, 1, 0, 0, 0, 0, "R4");
        step(1, 1, 1, 254, 1, 1, 8'h80, 0, 0, "R2");
        step(1, 1, 127, 129, 1, 2, 0, 0, 0, "R2");
        step(1, 200, 127, 129, 0, 0, 0, 0, 0, "R4");
        for (int i = 0; i < 30; i++) begin
            if (i % 3 == 0)
                step(1, $urandom_range(254, 1), $urandom_range(254, 1), $urandom_range(254, 1),
                     1, $urandom_range(3, 0), $urandom_range(255, 0), 0, 0, "R7");
            else
                rnd_sample(0, 0, "R2");
        end
        // R6/R9: double buffered writes held across steady and rising vsync.
        step(1, 80, 80, 80, 1, 0, 64, 1, 0, "R6");
        step(1, 80, 80, 80, 1, 1, 20, 1, 0, "R6");
        step(1, 80, 80, 80, 1, 2, 255, 1, 0, "R6");
        rnd_sample(1, 0, "R9");
        rnd_sample(1, 1, "R9");
        rnd_sample(1, 1, "R9");
        rnd_sample(1, 1, "R9");
        rnd_sample(1, 0, "R6");
        rnd_sample(1, 0, "R6");
        rnd_sample(1, 0, "R6");
        // R8: write in the same cycle as the falling edge.
        step(1, 90, 200, 60, 1, 3, 250, 1, 1, "R8");
        step(1, 90, 200, 60, 1, 2, 30, 1, 0, "R8");
        step(1, 90, 200, 60, 0, 0, 0, 1, 0, "R8");
        step(1, 90, 200, 60, 0, 0, 0, 1, 0, "R8");
        // Random mix of writes, vsync and buffering mode.
        for (int i = 0; i < 400; i++) begin
            bit db = (i / 100) % 2 == 0;
            bit vs = $urandom_range(7, 0) == 0 ? !prev_vs : prev_vs;
            step($urandom_range(3, 0) != 0, $urandom_range(254, 1), $urandom_range(254, 1),
                 $urandom_range(254, 1), $urandom_range(3, 0) == 0, $urandom_range(3, 0),
                 $urandom_range(255, 0), db, vs, db ? "R6" : "R7");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        check_out();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule